// File: doc/BRIEF.md
# DMA Channel Request Gating and Scheduler

This block chooses which DMA channel moves the next data element. Each channel supplies a configuration word and a remaining element count. From these, the block works out whether the channel may run. The channel must be enabled and not halted. Its flow-control code must be one of the supported values. The peripheral request lines that this code calls for must be active. Its count must be nonzero. A global enable gates the whole block.

Among the channels that may run, a rotating scan picks one and issues a registered one-hot grant with a valid strobe. The grant stays fixed until the data engine reports that the element is done. After that, the block waits one idle cycle so the engine can update the count, and then scans again.

The scan begins at the channel that was granted last and moves upward, wrapping past the highest index. A channel therefore keeps the grant for as long as it stays eligible. When it is no longer eligible, the next higher eligible channel takes over. The block does not move any data itself.

Top module: `dma_req_sched`

## Requirements
- R1: A channel is eligible only if its enable bit (configuration bit 0) is 1 and its halt bit (configuration bit 18) is 0.
- R2: The flow code sits in configuration bits 13:11, the source peripheral number in bits 5:1 and the destination peripheral number in bits 10:6. Code 0 needs no request. Code 1 needs the destination line. Code 2 needs the source line. Code 3 needs both lines. A line counts as active when either the single-request or the burst-request input for that peripheral is 1.
- R3: A channel whose remaining count (its 12-bit count word) is zero is never granted.
- R4: No new grant is issued while `glb_en` is 0.
- R5: Flow codes 4 to 7 make a channel ineligible. `flow_err` bit c is 1, in the same cycle, whenever channel c is enabled, not halted, and has a flow code of 4 or above.
- R6: At most one grant bit is 1 at any time. `grant_valid` is 1 exactly when a grant bit is 1.
- R7: When the block is idle and some channel is eligible at a clock edge, the grant appears after that edge. It is held unchanged until a cycle with `elem_done` set. It is 0 after that edge, so at least one idle cycle separates two grants.
- R8: The search begins at the channel granted last (channel 0 after reset) and goes upward with wrap. The first eligible channel found wins.
- R9: After reset the grant and `grant_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable for the block |
| chan_cfg | input | NUM_CH*19 | Per-channel configuration words; channel c occupies bits c*19 and up |
| chan_cnt | input | NUM_CH*CNT_W | Per-channel remaining element counts |
| req_single | input | 2**PID_W | Single-transfer request lines, one per peripheral |
| req_burst | input | 2**PID_W | Burst request lines, one per peripheral |
| elem_done | input | 1 | Engine has finished the element for the current grant |
| grant | output | NUM_CH | One-hot grant of the selected channel |
| grant_valid | output | 1 | A grant is being held |
| flow_err | output | NUM_CH | Per-channel flag for an unsupported flow code |

## Verification
The checker assumes that `elem_done` is raised only while a grant is held. It also assumes the engine has updated a channel's count by the end of the idle cycle that follows a release. The directed stimulus pulses `elem_done` for a single cycle, and only while `grant_valid` is 1. Any change to a channel's count or configuration is applied in the same cycle as that pulse, so the next scan already sees the new values.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int CFG_W    = 19;
  localparam int EN_BIT   = 0;
  localparam int HALT_BIT = 18;
  localparam int SRC_LSB  = 1;
  localparam int DST_LSB  = 6;
  localparam int FLOW_LSB = 11;
  localparam int FLOW_W   = 3;

  typedef enum logic [FLOW_W-1:0] {
    FLOW_FREE = 3'd0,
    FLOW_DST  = 3'd1,
    FLOW_SRC  = 3'd2,
    FLOW_BOTH = 3'd3
  } flow_e;

  // Whether the request lines satisfy the flow code; codes 4..7 never pass.
  function automatic logic flow_pass(logic [FLOW_W-1:0] code, logic src_rq, logic dst_rq);
    case (code)
      FLOW_FREE: flow_pass = 1'b1;
      FLOW_DST:  flow_pass = dst_rq;
      FLOW_SRC:  flow_pass = src_rq;
      FLOW_BOTH: flow_pass = src_rq & dst_rq;
      default:   flow_pass = 1'b0;
    endcase
  endfunction

  function automatic logic flow_unsupported(logic [FLOW_W-1:0] code);
    flow_unsupported = code[FLOW_W-1];
  endfunction
endpackage

// File: rtl/dma_chan_elig.sv
module dma_chan_elig
  import dma_sched_pkg::*;
#(
  parameter int PID_W = 5,
  parameter int CNT_W = 12,
  localparam int NP = 1 << PID_W
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic [CNT_W-1:0] cnt,
  input  logic [NP-1:0]    req_any,
  input  logic             glb_en,
  output logic             elig,
  output logic             bad_flow
);
  logic             ch_on;
  logic [PID_W-1:0] src_id, dst_id;
  logic [FLOW_W-1:0] code;
  logic             rq_ok;
  logic             unused_cfg_bits;

  assign unused_cfg_bits = ^cfg[HALT_BIT-1:FLOW_LSB+FLOW_W];

  assign ch_on  = cfg[EN_BIT] & ~cfg[HALT_BIT];
  assign src_id = cfg[SRC_LSB +: PID_W];
  assign dst_id = cfg[DST_LSB +: PID_W];
  assign code   = cfg[FLOW_LSB +: FLOW_W];
  assign rq_ok  = flow_pass(code, req_any[src_id], req_any[dst_id]);

  assign elig     = glb_en & ch_on & rq_ok & (cnt != '0);
  assign bad_flow = ch_on & flow_unsupported(code);
endmodule

// File: rtl/dma_rot_pick.sv
module dma_rot_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] start,
  output logic          any,
  output logic [IW-1:0] sel
);
  logic [IW:0] idx;

  // Walk offsets from highest to lowest so the smallest offset from start wins.
  always_comb begin
    any = 1'b0;
    sel = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      idx = {1'b0, start} + (IW+1)'(i);
      if (idx >= (IW+1)'(N)) idx = idx - (IW+1)'(N);
      if (cand[idx[IW-1:0]]) begin
        any = 1'b1;
        sel = idx[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/dma_req_sched.sv
module dma_req_sched
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PID_W  = 5,
  parameter int CNT_W  = 12,
  localparam int NP = 1 << PID_W,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_en,
  input  logic [NUM_CH*CFG_W-1:0] chan_cfg,
  input  logic [NUM_CH*CNT_W-1:0] chan_cnt,
  input  logic [NP-1:0]           req_single,
  input  logic [NP-1:0]           req_burst,
  input  logic                    elem_done,
  output logic [NUM_CH-1:0]       grant,
  output logic                    grant_valid,
  output logic [NUM_CH-1:0]       flow_err
);
  logic [NP-1:0]     req_any;
  logic [NUM_CH-1:0] elig_vec;
  logic              pick_any;
  logic [IW-1:0]     pick_sel;
  logic              busy;
  logic [IW-1:0]     gnt_idx;
  logic [IW-1:0]     scan_ptr;
  logic              start_grant;
  logic              release_grant;

  assign req_any = req_single | req_burst;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan_elig #(.PID_W(PID_W), .CNT_W(CNT_W)) u_elig (
      .cfg      (chan_cfg[c*CFG_W +: CFG_W]),
      .cnt      (chan_cnt[c*CNT_W +: CNT_W]),
      .req_any  (req_any),
      .glb_en   (glb_en),
      .elig     (elig_vec[c]),
      .bad_flow (flow_err[c])
    );
  end

  dma_rot_pick #(.N(NUM_CH)) u_pick (
    .cand  (elig_vec),
    .start (scan_ptr),
    .any   (pick_any),
    .sel   (pick_sel)
  );

  assign start_grant   = ~busy & pick_any;
  assign release_grant = busy & elem_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      gnt_idx  <= '0;
      scan_ptr <= '0;
    end else if (start_grant) begin
      busy     <= 1'b1;
      gnt_idx  <= pick_sel;
      scan_ptr <= pick_sel;
    end else if (release_grant) begin
      busy <= 1'b0;
    end
  end

  assign grant       = busy ? ({{(NUM_CH-1){1'b0}}, 1'b1} << gnt_idx) : '0;
  assign grant_valid = busy;
endmodule

// File: rtl/dma_req_sched_chk.sv
module dma_req_sched_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glb_en,
  input logic              elem_done,
  input logic [NUM_CH-1:0] grant,
  input logic              grant_valid,
  input logic [NUM_CH-1:0] flow_err,
  input logic [NUM_CH-1:0] elig_vec
);
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_valid == (grant != '0)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !elem_done |=> grant_valid && $stable(grant));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && elem_done |=> !grant_valid);

  a_r4_no_grant_off: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid && !glb_en |=> !grant_valid);

  a_r1_grant_was_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> (($past(elig_vec) & grant) != '0));

  a_r5_no_bad_flow_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> (($past(flow_err) & grant) == '0));
endmodule

bind dma_req_sched dma_req_sched_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .glb_en      (glb_en),
  .elem_done   (elem_done),
  .grant       (grant),
  .grant_valid (grant_valid),
  .flow_err    (flow_err),
  .elig_vec    (elig_vec)
);

// File: tb/dma_req_sched_test.sv
`timescale 1ns/1ps
module dma_req_sched_test;
  localparam int NCH = 8;
  localparam int CW  = 19;
  localparam int NW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b0;
  logic [NCH*CW-1:0] chan_cfg;
  logic [NCH*NW-1:0] chan_cnt;
  logic [31:0] req_single = '0;
  logic [31:0] req_burst = '0;
  logic elem_done = 1'b0;
  logic [NCH-1:0] grant, flow_err;
  logic grant_valid;

  logic [CW-1:0] cfg [NCH];
  logic [NW-1:0] cnt [NCH];

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      chan_cfg[c*CW +: CW] = cfg[c];
      chan_cnt[c*NW +: NW] = cnt[c];
    end
  end

  dma_req_sched uut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
    .chan_cfg(chan_cfg), .chan_cnt(chan_cnt),
    .req_single(req_single), .req_burst(req_burst),
    .elem_done(elem_done), .grant(grant),
    .grant_valid(grant_valid), .flow_err(flow_err)
  );

  function automatic logic [CW-1:0] mk(logic en, logic halt, logic [2:0] flow,
                                       logic [4:0] src, logic [4:0] dst);
    return {halt, 4'b0000, flow, dst, src, en};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_grant(string tag, logic [NCH-1:0] exp);
    chk(tag, {23'd0, grant_valid, grant}, {23'd0, exp != '0, exp});
  endtask

  task automatic release_elem();
    elem_done = 1'b1;
    @(negedge clk);
    elem_done = 1'b0;
  endtask

  task automatic cleanup();
    for (int c = 0; c < NCH; c++) begin cfg[c] = '0; cnt[c] = '0; end
    req_single = '0; req_burst = '0;
    if (grant_valid) release_elem();
    @(negedge clk);
    chk_grant("R7 idle after cleanup", '0);
  endtask

  task automatic t_reset();
    chk_grant("R9 reset state", '0);
  endtask

  task automatic t_global_and_rotation();
    glb_en = 1'b0;
    cfg[0] = mk(1, 0, 0, 0, 0); cnt[0] = 12'd3;
    repeat (3) @(negedge clk);
    chk_grant("R4 disabled globally", '0);
    glb_en = 1'b1;
    @(negedge clk);
    chk_grant("R1 R7 first grant", 8'h01);
    cfg[1] = mk(1, 0, 0, 0, 0); cnt[1] = 12'd2;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_grant("R7 grant held", 8'h01);
    end
    release_elem();
    chk_grant("R7 idle cycle after done", '0);
    @(negedge clk);
    chk_grant("R8 same channel kept", 8'h01);
    cnt[0] = '0;
    release_elem();
    chk_grant("R7 idle cycle", '0);
    @(negedge clk);
    chk_grant("R3 R8 move to next", 8'h02);
    cnt[0] = 12'd5;
    release_elem();
    @(negedge clk);
    chk_grant("R8 channel 1 retained over 0", 8'h02);
    cfg[1] = '0;
    release_elem();
    @(negedge clk);
    chk_grant("R8 wrap to channel 0", 8'h01);
    cleanup();
  endtask

  task automatic t_flow();
    cfg[3] = mk(1, 0, 3'd1, 5'd9, 5'd7); cnt[3] = 12'd4;
    repeat (2) @(negedge clk);
    chk_grant("R2 code1 no request", '0);
    req_single[9] = 1'b1;
    repeat (2) @(negedge clk);
    chk_grant("R2 code1 source only", '0);
    req_burst[7] = 1'b1;
    @(negedge clk);
    chk_grant("R2 code1 dest via burst", 8'h08);
    cfg[3] = mk(1, 0, 3'd2, 5'd9, 5'd7);
    req_single = '0; req_burst = '0; req_burst[9] = 1'b1;
    release_elem();
    @(negedge clk);
    chk_grant("R2 code2 source via burst", 8'h08);
    cfg[3] = mk(1, 0, 3'd3, 5'd9, 5'd7);
    release_elem();
    @(negedge clk);
    chk_grant("R2 code3 needs both", '0);
    req_single[7] = 1'b1;
    @(negedge clk);
    chk_grant("R2 code3 both present", 8'h08);
    cleanup();
  endtask

  task automatic t_halt();
    cfg[2] = mk(1, 1, 0, 0, 0); cnt[2] = 12'd2;
    repeat (2) @(negedge clk);
    chk_grant("R1 halted", '0);
    cfg[2] = mk(0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk_grant("R1 not enabled", '0);
    cfg[2] = mk(1, 0, 0, 0, 0);
    @(negedge clk);
    chk_grant("R1 R8 enabled from scan at 3", 8'h04);
    cleanup();
  endtask

  task automatic t_flow_err();
    cfg[5] = mk(1, 0, 3'd5, 0, 0); cnt[5] = 12'd3;
    #1;
    chk("R5 flow_err raised", {24'd0, flow_err}, 32'h20);
    repeat (2) @(negedge clk);
    chk_grant("R5 code5 not granted", '0);
    cfg[6] = mk(1, 0, 3'd7, 0, 0); cnt[6] = 12'd1;
    #1;
    chk("R5 two error flags", {24'd0, flow_err}, 32'h60);
    cfg[5] = mk(1, 1, 3'd5, 0, 0);
    #1;
    chk("R5 halted clears flag", {24'd0, flow_err}, 32'h40);
    @(negedge clk);
    chk_grant("R5 code7 not granted", '0);
    cleanup();
  endtask

  task automatic t_count_and_pick();
    cfg[4] = mk(1, 0, 0, 0, 0); cnt[4] = '0;
    repeat (2) @(negedge clk);
    chk_grant("R3 zero count", '0);
    cnt[4] = 12'd1;
    @(negedge clk);
    chk_grant("R3 nonzero count", 8'h10);
    cfg[4] = '0;
    cfg[1] = mk(1, 0, 0, 0, 0); cnt[1] = 12'd1;
    cfg[6] = mk(1, 0, 0, 0, 0); cnt[6] = 12'd1;
    cfg[7] = mk(1, 0, 0, 0, 0); cnt[7] = 12'd1;
    release_elem();
    @(negedge clk);
    chk_grant("R6 R8 three eligible from 4", 8'h40);
    cleanup();
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin cfg[c] = '0; cnt[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_global_and_rotation();
    t_flow();
    t_halt();
    t_flow_err();
    t_count_and_pick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule